// File: doc/BRIEF.md
# Core Power-Up Reset Sequencer

This block powers up one core of a small multi-core cluster and lets it run. A start request names a core by index. It also says whether the core is a small-core or a big-core type, and whether the build has a second power-on reset domain. The block then walks that core's reset and power controls through a fixed series of steps.

First the power-on reset is pulled low. The debug reset is asserted next, and for a small core the trace reset and the L1 reset-disable line are also driven low. The block then asks an external ramp controller to open the core's power switch and waits for it to report completion. After that it clears the core's power-gate bit and waits a fixed time before it lets go of the power-on reset. Last, it releases the debug and core resets together, plus the trace reset (small core) or the auxiliary-unit reset (big core).

All reset outputs are active-low. The per-core controls are vectors with one bit per core, and only the selected core's bits move during a sequence. The microsecond waits are counted in clock cycles from a cycles-per-microsecond parameter.

Top module: `corePwrSeq`

## Requirements
- R1: After reset, every reset vector (power-on, second power-on, debug, trace, core, auxiliary) is all zeros. The L1 reset-disable and power-gate vectors are all ones. The switch request, busy, done and error outputs are low.
- R2: A start request in idle with a core index of NUM_CORES or more raises the error output for exactly one cycle, starting the cycle after the request. No other output changes and busy stays low.
- R3: Busy goes high the cycle after an accepted start. While busy, start requests are ignored: they raise no error and touch no core's controls.
- R4: One cycle after acceptance, the selected core's power-on reset bit reads 0.
- R5: On the cycle the switch request rises, the selected core's debug reset is 0. For a small core the trace reset and L1 reset-disable bits are also 0. For a big core those two bits keep their previous values.
- R6: The switch request for the core stays high until the switch-done input is seen. On that cycle the request drops and the core's power-gate bit goes to 0.
- R7: The power-on reset bit returns to 1 exactly 20 microseconds' worth of cycles after the switch-done cycle.
- R8: The debug and core resets are released together, plus the trace reset for a small core or the auxiliary reset for a big core. This happens on the same cycle as the power-on release when the second domain is unused.
- R9: With the second domain enabled, its reset bit is cleared one cycle after the power-on reset. The debug reset is asserted 10 microseconds after that. The second reset is released together with the power-on reset, and the final release follows 10 microseconds later.
- R10: Done is a one-cycle pulse that coincides with the final release, and busy is low on that cycle.
- R11: Only the selected core's bits change during a sequence, and at most one switch request is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a power-up sequence |
| coreIdx | input | IDX_W | Index of the core to power up |
| isBig | input | 1 | 1 selects the big-core variant, 0 the small-core variant |
| dualPor | input | 1 | 1 enables the second power-on reset domain |
| swDone | input | 1 | Power switch ramp finished |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| startErr | output | 1 | One-cycle pulse for an out-of-range index |
| porN | output | NUM_CORES | Power-on reset per core, active-low |
| por2N | output | NUM_CORES | Second power-on reset per core, active-low |
| dbgRstN | output | NUM_CORES | Debug reset per core, active-low |
| traceRstN | output | NUM_CORES | Trace reset per core, active-low |
| coreRstN | output | NUM_CORES | Core reset per core, active-low |
| auxRstN | output | NUM_CORES | Auxiliary-unit reset per core, active-low |
| l1RstDis | output | NUM_CORES | L1 reset-disable per core |
| pwrGate | output | NUM_CORES | Power gate per core, 1 = gated |
| swReq | output | NUM_CORES | Power switch open request per core |

## Verification
A state machine that skips or reorders a step changes the cycle on which a control bit flips. The bench counts cycles between observable events: start to power-on assert, second reset to debug assert, switch-done to power-on release, and release to done. Any such fault therefore shows up within one sequence as a cycle-count mismatch. A wrong latched index or core type corrupts the full vector comparison made at the done pulse. A timer off by one cycle shows up at the first power-on release.

// File: rtl/corePwrPkg.sv
package corePwrPkg;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_LONG,
    LD_SHORT_PRE,
    LD_SHORT_POST
  } loadSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POR,
    ST_POR2,
    ST_WAIT_PRE,
    ST_PREP,
    ST_SWITCH,
    ST_WAIT_GATE,
    ST_WAIT_POST
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latch;
    logic     reject;
    logic     clrPor;
    logic     clrPor2;
    logic     prep;
    logic     swOpen;
    logic     relPor;
    logic     relPor2;
    logic     relFinal;
    loadSel_e loadSel;
  } seqCmd_t;

endpackage

// File: rtl/corePwrCtrl.sv
module corePwrCtrl
  import corePwrPkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [IDX_W-1:0] coreIdx,
  input  logic             dualPor,
  input  logic             swDone,
  input  logic             timerZero,
  output seqCmd_t          cmd,
  output logic             busy
);

  seqState_e state, nextState;
  logic dualQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      dualQ <= 1'b0;
    end else begin
      state <= nextState;
      if (cmd.latch) dualQ <= dualPor;
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.loadSel = LD_NONE;
    nextState   = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (coreIdx < IDX_W'(NUM_CORES)) begin
            cmd.latch = 1'b1;
            nextState = ST_POR;
          end else begin
            cmd.reject = 1'b1;
          end
        end
      end
      ST_POR: begin
        cmd.clrPor = 1'b1;
        nextState  = dualQ ? ST_POR2 : ST_PREP;
      end
      ST_POR2: begin
        cmd.clrPor2 = 1'b1;
        cmd.loadSel = LD_SHORT_PRE;
        nextState   = ST_WAIT_PRE;
      end
      ST_WAIT_PRE: begin
        if (timerZero) nextState = ST_PREP;
      end
      ST_PREP: begin
        cmd.prep  = 1'b1;
        nextState = ST_SWITCH;
      end
      ST_SWITCH: begin
        if (swDone) begin
          cmd.swOpen  = 1'b1;
          cmd.loadSel = LD_LONG;
          nextState   = ST_WAIT_GATE;
        end
      end
      ST_WAIT_GATE: begin
        if (timerZero) begin
          cmd.relPor = 1'b1;
          if (dualQ) begin
            cmd.relPor2 = 1'b1;
            cmd.loadSel = LD_SHORT_POST;
            nextState   = ST_WAIT_POST;
          end else begin
            cmd.relFinal = 1'b1;
            nextState    = ST_IDLE;
          end
        end
      end
      ST_WAIT_POST: begin
        if (timerZero) begin
          cmd.relFinal = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/corePwrPath.sv
module corePwrPath
  import corePwrPkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int IDX_W      = 3,
  parameter int CYC_PER_US = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCmd_t              cmd,
  input  logic [IDX_W-1:0]     coreIdx,
  input  logic                 isBig,
  output logic                 timerZero,
  output logic                 done,
  output logic                 startErr,
  output logic [NUM_CORES-1:0] porN,
  output logic [NUM_CORES-1:0] por2N,
  output logic [NUM_CORES-1:0] dbgRstN,
  output logic [NUM_CORES-1:0] traceRstN,
  output logic [NUM_CORES-1:0] coreRstN,
  output logic [NUM_CORES-1:0] auxRstN,
  output logic [NUM_CORES-1:0] l1RstDis,
  output logic [NUM_CORES-1:0] pwrGate,
  output logic [NUM_CORES-1:0] swReq
);

  localparam int CW        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int LONG_CYC  = 20 * CYC_PER_US;
  localparam int SHORT_CYC = 10 * CYC_PER_US;
  localparam int TW        = $clog2(LONG_CYC + 1);

  logic [CW-1:0] idxQ;
  logic          bigQ;
  logic [TW-1:0] timer;

  assign timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ     <= '0;
      bigQ     <= 1'b0;
      timer    <= '0;
      done     <= 1'b0;
      startErr <= 1'b0;
    end else begin
      done     <= cmd.relFinal;
      startErr <= cmd.reject;
      if (cmd.latch) begin
        idxQ <= coreIdx[CW-1:0];
        bigQ <= isBig;
      end
      case (cmd.loadSel)
        LD_LONG:       timer <= TW'(LONG_CYC - 1);
        LD_SHORT_PRE:  timer <= TW'(SHORT_CYC - 2);
        LD_SHORT_POST: timer <= TW'(SHORT_CYC - 1);
        default:       if (!timerZero) timer <= timer - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porN      <= '0;
      por2N     <= '0;
      dbgRstN   <= '0;
      traceRstN <= '0;
      coreRstN  <= '0;
      auxRstN   <= '0;
      l1RstDis  <= '1;
      pwrGate   <= '1;
      swReq     <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (idxQ == CW'(c)) begin
          if (cmd.clrPor)  porN[c]  <= 1'b0;
          if (cmd.clrPor2) por2N[c] <= 1'b0;
          if (cmd.prep) begin
            dbgRstN[c] <= 1'b0;
            swReq[c]   <= 1'b1;
            if (!bigQ) begin
              traceRstN[c] <= 1'b0;
              l1RstDis[c]  <= 1'b0;
            end
          end
          if (cmd.swOpen) begin
            swReq[c]   <= 1'b0;
            pwrGate[c] <= 1'b0;
          end
          if (cmd.relPor)  porN[c]  <= 1'b1;
          if (cmd.relPor2) por2N[c] <= 1'b1;
          if (cmd.relFinal) begin
            dbgRstN[c]  <= 1'b1;
            coreRstN[c] <= 1'b1;
            if (bigQ) auxRstN[c]   <= 1'b1;
            else      traceRstN[c] <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/corePwrSeq.sv
module corePwrSeq
  import corePwrPkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int IDX_W      = $clog2(NUM_CORES) + 1,
  parameter int CYC_PER_US = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [IDX_W-1:0]     coreIdx,
  input  logic                 isBig,
  input  logic                 dualPor,
  input  logic                 swDone,
  output logic                 busy,
  output logic                 done,
  output logic                 startErr,
  output logic [NUM_CORES-1:0] porN,
  output logic [NUM_CORES-1:0] por2N,
  output logic [NUM_CORES-1:0] dbgRstN,
  output logic [NUM_CORES-1:0] traceRstN,
  output logic [NUM_CORES-1:0] coreRstN,
  output logic [NUM_CORES-1:0] auxRstN,
  output logic [NUM_CORES-1:0] l1RstDis,
  output logic [NUM_CORES-1:0] pwrGate,
  output logic [NUM_CORES-1:0] swReq
);

  seqCmd_t cmd;
  logic    timerZero;

  corePwrCtrl #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .coreIdx(coreIdx),
    .dualPor(dualPor), .swDone(swDone), .timerZero(timerZero),
    .cmd(cmd), .busy(busy)
  );

  corePwrPath #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CYC_PER_US(CYC_PER_US)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .coreIdx(coreIdx), .isBig(isBig),
    .timerZero(timerZero), .done(done), .startErr(startErr),
    .porN(porN), .por2N(por2N), .dbgRstN(dbgRstN), .traceRstN(traceRstN),
    .coreRstN(coreRstN), .auxRstN(auxRstN), .l1RstDis(l1RstDis),
    .pwrGate(pwrGate), .swReq(swReq)
  );

endmodule

// File: rtl/corePwrSeqChk.sv
module corePwrSeqChk #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic                 done,
  input logic                 startErr,
  input logic [NUM_CORES-1:0] porN,
  input logic [NUM_CORES-1:0] dbgRstN,
  input logic [NUM_CORES-1:0] pwrGate,
  input logic [NUM_CORES-1:0] swReq
);

  // R5: a switch request is never raised while debug reset is released
  a_r5_dbg_before_switch: assert property (@(posedge clk) disable iff (!rstN)
    ((swReq & dbgRstN) == '0));

  // R7: power-on reset only rises on a core whose gate is open
  a_r7_por_after_gate: assert property (@(posedge clk) disable iff (!rstN)
    ((porN & ~$past(porN) & pwrGate) == '0));

  // R10: done coincides with idle and lasts one cycle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: a rejected start leaves the controls alone
  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    startErr |-> (!busy && $stable(porN) && $stable(dbgRstN) && $stable(pwrGate)));

  // R3: no error can come out of a busy cycle
  a_r3_busy_no_err: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !startErr);

  // R11: at most one switch request
  a_r11_one_switch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(swReq));

endmodule

bind corePwrSeq corePwrSeqChk #(.NUM_CORES(NUM_CORES)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .startErr(startErr),
  .porN(porN), .dbgRstN(dbgRstN), .pwrGate(pwrGate), .swReq(swReq)
);

// File: tb/tb_corePwrSeq.sv
`timescale 1ns/1ps
module tb_corePwrSeq;

  localparam int NC    = 4;
  localparam int IW    = 3;
  localparam int CPU   = 2;
  localparam int LONG  = 20 * CPU;
  localparam int SHORT = 10 * CPU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [IW-1:0] coreIdx = '0;
  logic isBig = 1'b0, dualPor = 1'b0, swDone = 1'b0;
  logic busy, done, startErr;
  logic [NC-1:0] porN, por2N, dbgRstN, traceRstN, coreRstN, auxRstN, l1RstDis, pwrGate, swReq;

  logic [NC-1:0] ePor, ePor2, eDbg, eTrc, eCore, eAux, eL1, eGate;

  int nChecks = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  corePwrSeq #(.NUM_CORES(NC), .IDX_W(IW), .CYC_PER_US(CPU)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .coreIdx(coreIdx),
    .isBig(isBig), .dualPor(dualPor), .swDone(swDone),
    .busy(busy), .done(done), .startErr(startErr),
    .porN(porN), .por2N(por2N), .dbgRstN(dbgRstN), .traceRstN(traceRstN),
    .coreRstN(coreRstN), .auxRstN(auxRstN), .l1RstDis(l1RstDis),
    .pwrGate(pwrGate), .swReq(swReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmpAll(input string tag);
    chk({tag, " porN"}, 32'(porN), 32'(ePor));
    chk({tag, " por2N"}, 32'(por2N), 32'(ePor2));
    chk({tag, " dbgRstN"}, 32'(dbgRstN), 32'(eDbg));
    chk({tag, " traceRstN"}, 32'(traceRstN), 32'(eTrc));
    chk({tag, " coreRstN"}, 32'(coreRstN), 32'(eCore));
    chk({tag, " auxRstN"}, 32'(auxRstN), 32'(eAux));
    chk({tag, " l1RstDis"}, 32'(l1RstDis), 32'(eL1));
    chk({tag, " pwrGate"}, 32'(pwrGate), 32'(eGate));
    chk({tag, " swReq"}, 32'(swReq), 32'd0);
  endtask

  function automatic logic [NC-1:0] setBit(input logic [NC-1:0] v, input int i, input logic b);
    logic [NC-1:0] r;
    r = v;
    r[i] = b;
    return r;
  endfunction

  task automatic rejectIdx(input int v);
    @(negedge clk);
    startReq = 1'b1;
    coreIdx = IW'(v);
    @(negedge clk);
    startReq = 1'b0;
    chk("R2 error pulse", 32'(startErr), 1);
    chk("R2 stays idle", 32'(busy), 0);
    cmpAll("R2 unchanged");
    @(negedge clk);
    chk("R2 error one cycle", 32'(startErr), 0);
  endtask

  task automatic runSeq(input int idx, input bit big, input bit dual, input int swDly, input bit poke);
    int cnt;
    @(negedge clk);
    startReq = 1'b1;
    coreIdx = IW'(idx);
    isBig = big;
    dualPor = dual;
    @(negedge clk);
    startReq = 1'b0;
    chk("R3 busy after accept", 32'(busy), 1);
    if (poke) begin
      startReq = 1'b1;
      coreIdx = IW'((idx + 1) % NC);
      isBig = ~big;
    end
    @(negedge clk);
    startReq = 1'b0;
    chk("R4 power-on reset asserted", 32'(porN[idx]), 0);
    chk("R3 no error while busy", 32'(startErr), 0);
    cnt = 0;
    while (!swReq[idx] && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    chk("R9 prep delay", 32'(cnt), dual ? 32'(SHORT + 1) : 32'd1);
    chk("R5 debug reset asserted", 32'(dbgRstN[idx]), 0);
    chk("R5 l1 reset-disable", 32'(l1RstDis[idx]), big ? 32'(eL1[idx]) : 32'd0);
    chk("R5 trace reset", 32'(traceRstN[idx]), big ? 32'(eTrc[idx]) : 32'd0);
    chk("R9 second reset", 32'(por2N[idx]), dual ? 32'd0 : 32'(ePor2[idx]));
    chk("R11 single switch request", 32'(swReq), 32'(setBit('0, idx, 1'b1)));
    repeat (swDly) @(negedge clk);
    chk("R6 request held", 32'(swReq[idx]), 1);
    chk("R6 gate before switch done", 32'(pwrGate[idx]), 32'(eGate[idx]));
    swDone = 1'b1;
    @(negedge clk);
    swDone = 1'b0;
    chk("R6 request dropped", 32'(swReq[idx]), 0);
    chk("R6 gate opened", 32'(pwrGate[idx]), 0);
    cnt = 0;
    while (!porN[idx] && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    chk("R7 gate to power-on release", 32'(cnt), 32'(LONG));
    chk("R8 release with power-on when single domain", 32'(done), dual ? 32'd0 : 32'd1);
    if (dual) begin
      chk("R9 second reset released", 32'(por2N[idx]), 1);
      chk("R9 debug still held", 32'(dbgRstN[idx]), 0);
      cnt = 0;
      while (!done && cnt < 1000) begin
        @(negedge clk);
        cnt++;
      end
      chk("R9 post wait", 32'(cnt), 32'(SHORT));
    end
    ePor  = setBit(ePor, idx, 1'b1);
    if (dual) ePor2 = setBit(ePor2, idx, 1'b1);
    eDbg  = setBit(eDbg, idx, 1'b1);
    eCore = setBit(eCore, idx, 1'b1);
    eGate = setBit(eGate, idx, 1'b0);
    if (big) eAux = setBit(eAux, idx, 1'b1);
    else begin
      eTrc = setBit(eTrc, idx, 1'b1);
      eL1  = setBit(eL1, idx, 1'b0);
    end
    cmpAll("R8 R11 final");
    chk("R10 busy low with done", 32'(busy), 0);
    @(negedge clk);
    chk("R10 done one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7177));
    ePor = '0; ePor2 = '0; eDbg = '0; eTrc = '0; eCore = '0; eAux = '0;
    eL1 = '1; eGate = '1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmpAll("R1 reset");
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 error", 32'(startErr), 0);

    rejectIdx(4);
    rejectIdx(7);
    runSeq(0, 1'b0, 1'b0, 3, 1'b0);
    runSeq(3, 1'b1, 1'b1, 0, 1'b1);
    runSeq(1, 1'b0, 1'b1, 5, 1'b0);
    runSeq(2, 1'b1, 1'b0, 1, 1'b1);
    runSeq(0, 1'b1, 1'b1, 2, 1'b0);
    for (int n = 0; n < 16; n++) begin
      if ($urandom_range(4, 0) == 0) rejectIdx(int'($urandom_range(7, 4)));
      runSeq(int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
             int'($urandom_range(6, 0)), 1'($urandom_range(1, 0)));
    end

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule